// File: doc/BRIEF.md
# Folded Symmetric Six-Tap FIR Filter

This block is a six-tap FIR filter with fixed coefficients. Its impulse response is mirror-symmetric, so the first and sixth weights are equal, the second and fifth are equal, and the third and fourth are equal. Before any multiplication, the block adds together each pair of delayed samples that share a weight. Three constant multipliers then serve all six taps, and an adder sums the three products into one output sample.

Samples arrive in sign-magnitude form, one sample per cycle in which the valid strobe is high. The block converts each sample to two's complement on entry. A five-stage history keeps the older samples. The filtered result is registered, and it is presented in two's complement on an output that is wide enough to hold every possible sum. Cycles in which the strobe is low leave the filter state unchanged, so the host can pace the sample stream freely.

Top module: `sym_fir6`

## Requirements
- R1: When the synchronous reset is high at a clock edge, the block clears out_valid, out_data and all five history stages to zero. The first outputs after reset are therefore computed against an all-zero history.
- R2: out_valid equals the value in_valid had at the previous clock edge. The latency is exactly one register stage.
- R3: For each accepted sample x0, with x1..x5 the previously accepted samples from newest to oldest, the next out_data equals C0*(x0+x5) + C1*(x1+x4) + C2*(x2+x3). This is identical to the unfolded six-tap direct form with weights C0, C1, C2, C2, C1, C0, so a single unit sample produces that weight sequence at the output.
- R4: in_data is sign-magnitude. Bit DATA_W-1 is the sign (1 means negative) and the low DATA_W-1 bits are the magnitude. A negative zero is treated exactly like zero.
- R5: On a cycle where in_valid is low, in_data is ignored. Neither the history nor out_data changes.
- R6: out_data is two's complement and DATA_W+COEF_W+3 bits wide. Full-scale samples of either sign combined with any coefficient values, including the most negative one, give the exact arithmetic result with no overflow or wrap.
- R7: After six equal accepted samples of value s, out_data equals 2*(C0+C1+C2)*s. This is the step response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the filter advances when high |
| in_data | input | DATA_W | Sign-magnitude input sample |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | DATA_W+COEF_W+3 | Two's complement filtered sample |

## Verification
The bench builds the filter with 8-bit samples and 8-bit weights. It sets the first weight to -128, the most negative value, sets the second to 127, and sets the third to 45. This places the largest weight magnitudes and mixed signs within reach, so full-scale samples push the result toward the edge of the output range and check the width sizing. With all three weights distinct, a unit impulse shows whether each weight lands on the correct pair of taps and in the correct order. With 8-bit samples, the negative-zero code and the full-scale magnitudes of both signs are easy to drive directly.

// File: rtl/fir6_pkg.sv
package fir6_pkg;
  localparam int NUM_TAPS  = 6;
  localparam int NUM_PAIRS = NUM_TAPS / 2;
  localparam int HIST_LEN  = NUM_TAPS - 1;

  // pre-add adds one bit, the three-product sum adds two more
  function automatic int fir6_out_width(input int data_w, input int coef_w);
    return data_w + coef_w + 3;
  endfunction
endpackage

// File: rtl/fir6_sm2tc.sv
module fir6_sm2tc #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sm_in,
  output logic [DATA_W-1:0] tc_out
);
  logic [DATA_W-1:0] mag_ext;

  always_comb begin
    mag_ext = {1'b0, sm_in[DATA_W-2:0]};
    // negative zero maps onto zero because -0 == 0 in two's complement
    tc_out  = sm_in[DATA_W-1] ? (~mag_ext + 1'b1) : mag_ext;
  end
endmodule

// File: rtl/fir6_tapline.sv
module fir6_tapline #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic [DATA_W-1:0]            din,
  output logic [DEPTH-1:0][DATA_W-1:0] taps
);
  logic [DEPTH-1:0][DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else if (adv) stage_q[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else if (adv) stage_q[g] <= stage_q[g-1];
    end
  end

  assign taps = stage_q;
endmodule

// File: rtl/fir6_preadd.sv
module fir6_preadd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W:0]   sum
);
  always_comb begin
    sum = {a[DATA_W-1], a} + {b[DATA_W-1], b};
  end
endmodule

// File: rtl/fir6_cmac.sv
module fir6_cmac #(
  parameter int                        PAIR_W = 9,
  parameter int                        COEF_W = 8,
  parameter int                        OUT_W  = 19,
  parameter int                        NPAIR  = 3,
  parameter logic [NPAIR*COEF_W-1:0]   COEFS  = '0
) (
  input  logic [NPAIR-1:0][PAIR_W-1:0] pair_sum,
  output logic [OUT_W-1:0]             total
);
  logic [NPAIR-1:0][OUT_W-1:0] prod;

  for (genvar k = 0; k < NPAIR; k++) begin : g_mul
    localparam logic [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
    logic signed [OUT_W-1:0] p_ext;
    logic signed [OUT_W-1:0] c_ext;
    always_comb begin
      p_ext   = {{(OUT_W-PAIR_W){pair_sum[k][PAIR_W-1]}}, pair_sum[k]};
      c_ext   = {{(OUT_W-COEF_W){CK[COEF_W-1]}}, CK};
      prod[k] = p_ext * c_ext;
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NPAIR; k++) total = total + prod[k];
  end
endmodule

// File: rtl/sym_fir6.sv
module sym_fir6 #(
  parameter int                 DATA_W = 8,
  parameter int                 COEF_W = 8,
  parameter logic signed [7:0]  C0     = 8'sd3,
  parameter logic signed [7:0]  C1     = -8'sd5,
  parameter logic signed [7:0]  C2     = 8'sd20,
  localparam int                OUT_W  = fir6_pkg::fir6_out_width(DATA_W, COEF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  import fir6_pkg::*;

  localparam int PAIR_W = DATA_W + 1;
  localparam logic [COEF_W-1:0] CW0 = COEF_W'(C0);
  localparam logic [COEF_W-1:0] CW1 = COEF_W'(C1);
  localparam logic [COEF_W-1:0] CW2 = COEF_W'(C2);
  localparam logic [NUM_PAIRS*COEF_W-1:0] COEF_VEC = {CW2, CW1, CW0};

  logic [DATA_W-1:0]                    cur_tc;
  logic [HIST_LEN-1:0][DATA_W-1:0]      hist;
  logic [NUM_TAPS-1:0][DATA_W-1:0]      all_taps;
  logic [NUM_PAIRS-1:0][PAIR_W-1:0]     pair_sum;
  logic [OUT_W-1:0]                     total;

  fir6_sm2tc #(.DATA_W(DATA_W)) u_conv (
    .sm_in  (in_data),
    .tc_out (cur_tc)
  );

  fir6_tapline #(.DATA_W(DATA_W), .DEPTH(HIST_LEN)) u_line (
    .clk  (clk),
    .rst  (rst),
    .adv  (in_valid),
    .din  (cur_tc),
    .taps (hist)
  );

  always_comb begin
    all_taps[0] = cur_tc;
    for (int i = 1; i < NUM_TAPS; i++) all_taps[i] = hist[i-1];
  end

  // mirrored taps k and NUM_TAPS-1-k share a weight
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    fir6_preadd #(.DATA_W(DATA_W)) u_add (
      .a   (all_taps[k]),
      .b   (all_taps[NUM_TAPS-1-k]),
      .sum (pair_sum[k])
    );
  end

  fir6_cmac #(
    .PAIR_W (PAIR_W),
    .COEF_W (COEF_W),
    .OUT_W  (OUT_W),
    .NPAIR  (NUM_PAIRS),
    .COEFS  (COEF_VEC)
  ) u_mac (
    .pair_sum (pair_sum),
    .total    (total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= total;
    end
  end
endmodule

// File: rtl/fir6_chk.sv
module fir6_chk #(
  parameter int                DATA_W = 8,
  parameter int                COEF_W = 8,
  parameter logic signed [7:0] C0     = 8'sd3,
  parameter logic signed [7:0] C1     = -8'sd5,
  parameter logic signed [7:0] C2     = 8'sd20,
  parameter int                OUT_W  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data
);
  localparam longint A0 = (longint'(C0) < 0) ? -longint'(C0) : longint'(C0);
  localparam longint A1 = (longint'(C1) < 0) ? -longint'(C1) : longint'(C1);
  localparam longint A2 = (longint'(C2) < 0) ? -longint'(C2) : longint'(C2);
  localparam longint MAXMAG = (longint'(1) << (DATA_W-1)) - 1;
  localparam longint BOUND  = 2 * MAXMAG * (A0 + A1 + A2);

  longint out_val;
  always_comb out_val = longint'($signed(out_data));

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (out_valid == 1'b0 && out_data == '0));

  // R2: one-stage valid latency
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R5: stall cycles leave the result untouched
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R6: result never leaves the reachable range
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_val <= BOUND && out_val >= -BOUND));
endmodule

bind sym_fir6 fir6_chk #(
  .DATA_W (DATA_W),
  .COEF_W (COEF_W),
  .C0     (C0),
  .C1     (C1),
  .C2     (C2),
  .OUT_W  (OUT_W)
) u_fir6_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_sym_fir6.sv
module test_sym_fir6;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + 3;
  localparam int K0 = -128;
  localparam int K1 = 127;
  localparam int K2 = 45;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    hist[$];
  int    exp_d = 0;
  bit    exp_v = 0;
  string pend_tag = "R1";

  sym_fir6 #(.DATA_W(DW), .COEF_W(CW), .C0(8'sd0 - 8'sd128), .C1(8'sd127), .C2(8'sd45))
    i_sym_fir6 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sm_val(input logic [DW-1:0] d);
    int m = int'(d[DW-2:0]);
    return d[DW-1] ? -m : m;
  endfunction

  task automatic clear_model();
    hist = {};
    for (int i = 0; i < 6; i++) hist.push_back(0);
    exp_d = 0;
    exp_v = 0;
  endtask

  task automatic compare(input string tag);
    int got = int'($signed(out_data));
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL R2 out_valid: actual %0b expected %0b", out_valid, exp_v);
    end
    checks++;
    if (got != exp_d || $isunknown(out_data)) begin
      errors++;
      $display("FAIL %s out_data: actual %0d expected %0d", tag, got, exp_d);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic r, input string tag);
    @(negedge clk);
    compare(pend_tag);
    rst = r; in_valid = v; in_data = d;
    if (r) clear_model();
    else begin
      exp_v = v;
      if (v) begin
        void'(hist.pop_back());
        hist.push_front(sm_val(d));
        exp_d = K0*(hist[0]+hist[5]) + K1*(hist[1]+hist[4]) + K2*(hist[2]+hist[3]);
      end
    end
    pend_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    // R1: reset dominates valid data
    for (int i = 0; i < 3; i++) step(1'b1, 8'h55, 1'b1, "R1");
    // R3: unit impulse yields C0 C1 C2 C2 C1 C0
    step(1'b1, 8'h01, 1'b0, "R3");
    for (int i = 0; i < 7; i++) step(1'b1, 8'h00, 1'b0, "R3");
    // R7: step response settles to 2*(C0+C1+C2)*s
    for (int i = 0; i < 8; i++) step(1'b1, 8'h0A, 1'b0, "R7");
    step(1'b1, 8'h00, 1'b0, "R7");
    // R4: negative values and negative zero
    step(1'b1, 8'h85, 1'b0, "R4");
    step(1'b1, 8'h80, 1'b0, "R4");
    step(1'b1, 8'h03, 1'b0, "R4");
    step(1'b1, 8'h80, 1'b0, "R4");
    step(1'b1, 8'hC0, 1'b0, "R4");
    for (int i = 0; i < 5; i++) step(1'b1, 8'h80, 1'b0, "R4");
    // R5: stalls with junk data in between
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 8'(i*7 + 1), 1'b0, "R5");
      step(1'b0, 8'hFF - 8'(i), 1'b0, "R5");
      step(1'b0, 8'h7F, 1'b0, "R5");
    end
    // R6: full scale, sign pattern pushing every product the same way
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8'hFF, 1'b0, "R6"); step(1'b1, 8'h7F, 1'b0, "R6");
      step(1'b1, 8'h7F, 1'b0, "R6"); step(1'b1, 8'h7F, 1'b0, "R6");
      step(1'b1, 8'h7F, 1'b0, "R6"); step(1'b1, 8'hFF, 1'b0, "R6");
    end
    for (int i = 0; i < 8; i++) step(1'b1, (i % 2) ? 8'hFF : 8'h7F, 1'b0, "R6");
    for (int i = 0; i < 7; i++) step(1'b1, 8'hFF, 1'b0, "R6");
    // R1: mid-stream reset, then impulse must see zero history
    step(1'b1, 8'h7F, 1'b1, "R1");
    step(1'b1, 8'h81, 1'b0, "R1");
    for (int i = 0; i < 6; i++) step(1'b1, 8'h00, 1'b0, "R1");
    // R3: mixed random stream with random stalls
    for (int i = 0; i < 120; i++) step(1'($urandom_range(0, 3) != 0), 8'($urandom), 1'b0, "R3");
    step(1'b0, 8'h00, 1'b0, "R3");
    @(negedge clk);
    compare(pend_tag);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule